// File: doc/BRIEF.md
# Data address watchpoint matcher

This block compares every load and store against one programmable window of memory and raises a hit flag for a matching access. Software sets the window through two registers. The base register holds the doubleword-aligned start address. The control register holds a doubleword count, enables for read and write matching, and three enables, one for each privilege class.

Each cycle the memory pipeline presents an access to the block. An access carries a valid bit, a write indication, its effective address, its size in bytes and the current privilege code. The hit flag is registered and appears on the cycle after the access is presented. This gives the pipeline room to stop the access before it takes effect. A register write changes the matching that applies to accesses presented from the following cycle on.

Top module: `dwatch_top`

## Requirements
- R1: The base register drops address bits [2:0] on every write. It reads back with those three bits zero, so the window always starts on an 8-byte boundary.
- R2: The control register keeps only these fields, at these little-endian bit positions: doubleword count [15:10], cross-range flag [7], write enable [6], read enable [5], hypervisor enable [2], supervisor enable [1], problem-state enable [0]. Every other bit reads back as zero.
- R3: The window covers `(count + 1) * 8` bytes starting at the base. An access hits only when its byte range `[ea, ea+size)` overlaps that window.
- R4: A write access can hit only while the write enable is set. A read access can hit only while the read enable is set. With both enables clear, no hit is produced.
- R5: The privilege codes are 00 (problem state), 01 (supervisor) and 10 (hypervisor). Each code needs its own enable bit (0, 1 and 2) to be set before it can hit. Code 11 never hits, and with all three enables clear no hit is produced.
- R6: The hit output rises on the cycle after the matching access is presented. A register write updates the value read back on the next cycle. That new value applies to accesses presented from that cycle on, while an access presented in the same cycle as the write uses the old value.
- R7: Reset clears both registers and the hit output, which leaves matching disabled.
- R8: The cross-range flag can be written and read back but does not change any hit decision.
- R9: Address sums are formed one bit wider than the address, so a window that reaches past the top of the address space does not wrap around to address zero. An access with valid low or a size of zero never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Write strobe for the base register |
| base_wdata | input | ADDR_W | Base register write data |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 64 | Control register write data |
| acc_valid | input | 1 | A memory access is presented this cycle |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_ea | input | ADDR_W | Effective address of the access |
| acc_size | input | SZ_W | Access size in bytes |
| acc_priv | input | 2 | Current privilege code |
| base_rdata | output | ADDR_W | Base register read-back |
| ctrl_rdata | output | 64 | Control register read-back |
| wp_hit | output | 1 | Registered watchpoint hit |

## Verification
The bench builds the block with its default parameters: a 64-bit address and a 4-bit size field, so accesses of up to 15 bytes can be presented. The full 64-bit address lets the bench place a window in the last doubleword of the address space and then check that an access at address zero does not hit, which tests the no-wrap rule. The 6-bit count reaches windows of 512 bytes. A 4-bit size lets accesses straddle either edge of the window by several bytes.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;

    localparam int CTRL_W   = 64;
    localparam int CNT_W    = 6;
    localparam int CNT_LSB  = 10;
    localparam int XR_BIT   = 7;
    localparam int WEN_BIT  = 6;
    localparam int REN_BIT  = 5;
    localparam int HYP_BIT  = 2;
    localparam int SUP_BIT  = 1;
    localparam int PRB_BIT  = 0;
    localparam int ALIGN_B  = 3;

    typedef enum logic [1:0] {
        PRIV_PROB = 2'b00,
        PRIV_SUP  = 2'b01,
        PRIV_HYP  = 2'b10,
        PRIV_NONE = 2'b11
    } priv_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             xrange;
        logic             wr_en;
        logic             rd_en;
        logic             hyp_en;
        logic             sup_en;
        logic             prb_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] v);
        ctrl_t c;
        c.cnt    = v[CNT_LSB +: CNT_W];
        c.xrange = v[XR_BIT];
        c.wr_en  = v[WEN_BIT];
        c.rd_en  = v[REN_BIT];
        c.hyp_en = v[HYP_BIT];
        c.sup_en = v[SUP_BIT];
        c.prb_en = v[PRB_BIT];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
        logic [CTRL_W-1:0] v;
        v = '0;
        v[CNT_LSB +: CNT_W] = c.cnt;
        v[XR_BIT]  = c.xrange;
        v[WEN_BIT] = c.wr_en;
        v[REN_BIT] = c.rd_en;
        v[HYP_BIT] = c.hyp_en;
        v[SUP_BIT] = c.sup_en;
        v[PRB_BIT] = c.prb_en;
        return v;
    endfunction

    function automatic logic priv_allowed(input ctrl_t c, input priv_e p);
        logic ok;
        case (p)
            PRIV_PROB: ok = c.prb_en;
            PRIV_SUP:  ok = c.sup_en;
            PRIV_HYP:  ok = c.hyp_en;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/dwatch_regs.sv
module dwatch_regs
    import dwatch_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [ADDR_W-1:0] base_q,
    output ctrl_t             ctrl_q
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << ALIGN_B) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (base_we) base_q <= base_wdata & ALIGN_MASK;
            if (ctrl_we) ctrl_q <= ctrl_unpack(ctrl_wdata);
        end
    end
endmodule

// File: rtl/dwatch_range.sv
module dwatch_range
    import dwatch_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SZ_W   = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ADDR_W-1:0] ea,
    input  logic [SZ_W-1:0]   size,
    output logic              overlap
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] len_x, win_lo, win_hi, acc_lo, acc_hi;

    always_comb begin
        len_x   = (EXT_W'(cnt) + EXT_W'(1)) << ALIGN_B;
        win_lo  = EXT_W'(base);
        win_hi  = win_lo + len_x;
        acc_lo  = EXT_W'(ea);
        acc_hi  = acc_lo + EXT_W'(size);
        overlap = (size != '0) && (acc_lo < win_hi) && (win_lo < acc_hi);
    end
endmodule

// File: rtl/dwatch_gate.sv
module dwatch_gate
    import dwatch_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  valid,
    input  logic  is_write,
    input  priv_e priv,
    input  logic  overlap,
    output logic  hit_d
);
    logic type_ok, priv_ok;

    always_comb begin
        type_ok = is_write ? ctrl.wr_en : ctrl.rd_en;
        priv_ok = priv_allowed(ctrl, priv);
        hit_d   = valid && overlap && type_ok && priv_ok;
    end
endmodule

// File: rtl/dwatch_top.sv
module dwatch_top
    import dwatch_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SZ_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              ctrl_we,
    input  logic [63:0]       ctrl_wdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_ea,
    input  logic [SZ_W-1:0]   acc_size,
    input  logic [1:0]        acc_priv,
    output logic [ADDR_W-1:0] base_rdata,
    output logic [63:0]       ctrl_rdata,
    output logic              wp_hit
);
    logic [ADDR_W-1:0] base_q;
    ctrl_t             ctrl_q;
    logic              overlap;
    logic              hit_d;

    dwatch_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .base_we    (base_we),
        .base_wdata (base_wdata),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .base_q     (base_q),
        .ctrl_q     (ctrl_q)
    );

    dwatch_range #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) range_i (
        .base    (base_q),
        .cnt     (ctrl_q.cnt),
        .ea      (acc_ea),
        .size    (acc_size),
        .overlap (overlap)
    );

    dwatch_gate gate_i (
        .ctrl     (ctrl_q),
        .valid    (acc_valid),
        .is_write (acc_write),
        .priv     (priv_e'(acc_priv)),
        .overlap  (overlap),
        .hit_d    (hit_d)
    );

    always_ff @(posedge clk) begin
        if (rst) wp_hit <= 1'b0;
        else     wp_hit <= hit_d;
    end

    assign base_rdata = base_q;
    assign ctrl_rdata = ctrl_pack(ctrl_q);
endmodule

// File: rtl/dwatch_chk.sv
module dwatch_chk #(
    parameter int ADDR_W = 64,
    parameter int SZ_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              base_we,
    input logic [ADDR_W-1:0] base_wdata,
    input logic              ctrl_we,
    input logic [63:0]       ctrl_wdata,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_ea,
    input logic [SZ_W-1:0]   acc_size,
    input logic [1:0]        acc_priv,
    input logic [ADDR_W-1:0] base_rdata,
    input logic [63:0]       ctrl_rdata,
    input logic              wp_hit
);
    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (base_rdata == '0 && ctrl_rdata == '0 && !wp_hit)); // R7

    AST_BASE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        ($past(base_we) && !$past(rst)) |->
            base_rdata == {$past(base_wdata[ADDR_W-1:3]), 3'b000}); // R1

    AST_HIT_NEEDS_ACC: assert property (@(posedge clk) disable iff (rst)
        wp_hit |-> ($past(acc_valid) && $past(acc_size) != '0)); // R9

    AST_HIT_TYPE_EN: assert property (@(posedge clk) disable iff (rst)
        wp_hit |-> ($past(acc_write) ? $past(ctrl_rdata[6]) : $past(ctrl_rdata[5]))); // R4

    AST_HIT_PRIV_EN: assert property (@(posedge clk) disable iff (rst)
        wp_hit |-> (($past(acc_priv) == 2'b00 && $past(ctrl_rdata[0])) ||
                    ($past(acc_priv) == 2'b01 && $past(ctrl_rdata[1])) ||
                    ($past(acc_priv) == 2'b10 && $past(ctrl_rdata[2])))); // R5
endmodule

bind dwatch_top dwatch_chk #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) chk_i (.*);

// File: tb/dwatch_top_tb_top.sv
`timescale 1ns/1ps
module dwatch_top_tb_top;
    localparam int ADDR_W = 64;
    localparam int SZ_W   = 4;
    localparam real CLK_P = 20.0;
    localparam logic [63:0] CTRL_KEEP = 64'h0000_0000_0000_FCE7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              base_we = 0, ctrl_we = 0;
    logic [ADDR_W-1:0] base_wdata = '0;
    logic [63:0]       ctrl_wdata = '0;
    logic              acc_valid = 0, acc_write = 0;
    logic [ADDR_W-1:0] acc_ea = '0;
    logic [SZ_W-1:0]   acc_size = '0;
    logic [1:0]        acc_priv = '0;
    logic [ADDR_W-1:0] base_rdata;
    logic [63:0]       ctrl_rdata;
    logic              wp_hit;

    int checks = 0, errors = 0;
    logic [63:0] m_base = '0, m_ctrl = '0;

    always #(CLK_P/2) clk = ~clk;

    dwatch_top #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) dut_i (.*);

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        finish_run();
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit model_hit(bit v, bit w, logic [63:0] ea, int sz, logic [1:0] pv);
        logic [64:0] lo, hi, alo, ahi;
        bit ty, pr;
        if (!v || sz == 0) return 0;
        ty = w ? m_ctrl[6] : m_ctrl[5];
        pr = (pv == 0) ? m_ctrl[0] : (pv == 1) ? m_ctrl[1] : (pv == 2) ? m_ctrl[2] : 1'b0;
        lo  = {1'b0, m_base};
        hi  = lo + 65'((int'(m_ctrl[15:10]) + 1) * 8);
        alo = {1'b0, ea};
        ahi = alo + 65'(sz);
        return ty && pr && (alo < hi) && (lo < ahi);
    endfunction

    // One clock: drive at a falling edge, predict, check at the next falling edge.
    task automatic step(string tag, bit v, bit w, logic [63:0] ea, int sz, logic [1:0] pv,
                        bit bwe = 0, logic [63:0] bwd = 0, bit cwe = 0, logic [63:0] cwd = 0);
        bit exp;
        acc_valid = v; acc_write = w; acc_ea = ea; acc_size = SZ_W'(sz); acc_priv = pv;
        base_we = bwe; base_wdata = bwd; ctrl_we = cwe; ctrl_wdata = cwd;
        exp = model_hit(v, w, ea, sz, pv);
        if (bwe) m_base = bwd & ~64'h7;
        if (cwe) m_ctrl = cwd & CTRL_KEEP;
        @(negedge clk);
        chk({tag, " hit"}, {63'b0, wp_hit}, {63'b0, exp});
        chk({tag, " base"}, base_rdata, m_base);
        chk({tag, " ctrl"}, ctrl_rdata, m_ctrl);
        base_we = 0; ctrl_we = 0; acc_valid = 0;
    endtask

    function automatic logic [63:0] mk_ctrl(int cnt, bit xr, bit we, bit re, bit hy, bit su, bit pb);
        return (64'(cnt) << 10) | (64'(xr) << 7) | (64'(we) << 6) | (64'(re) << 5) |
               (64'(hy) << 2) | (64'(su) << 1) | 64'(pb);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R7: reset state
        chk("R7 reset hit", {63'b0, wp_hit}, 64'd0);
        chk("R7 reset base", base_rdata, 64'd0);
        chk("R7 reset ctrl", ctrl_rdata, 64'd0);
        step("R7 reset no match", 1, 1, 64'h0, 8, 0);
        // R1: alignment
        step("R1 base write", 0, 0, 0, 0, 0, 1, 64'h1007);
        // R2: readback masks unknown bits
        step("R2 ctrl write", 0, 0, 0, 0, 0, 0, 0, 1, 64'hFFFF_0000_0000_0000 | mk_ctrl(0, 0, 1, 0, 1, 1, 1) | 64'h318);
        // R3/R4 basic matching
        step("R3 exact hit", 1, 1, 64'h1000, 8, 0);
        step("R4 read disabled", 1, 0, 64'h1000, 8, 0);
        step("R3 below adjacent", 1, 1, 64'hFF8, 8, 0);
        step("R3 partial overlap low", 1, 1, 64'hFFC, 8, 0);
        step("R3 above end cnt0", 1, 1, 64'h1008, 1, 2);
        step("R3 cnt3", 0, 0, 0, 0, 0, 0, 0, 1, mk_ctrl(3, 0, 1, 1, 1, 1, 1));
        step("R3 last byte", 1, 0, 64'h101F, 1, 1);
        step("R3 past end", 1, 0, 64'h1020, 8, 1);
        step("R4 read enabled", 1, 0, 64'h1008, 4, 0);
        step("R4 both off", 1, 1, 64'h1000, 8, 0, 0, 0, 1, mk_ctrl(3, 0, 0, 0, 1, 1, 1));
        step("R4 both off read", 1, 0, 64'h1000, 8, 0);
        step("R4 both off write", 1, 1, 64'h1010, 8, 2);
        // R5: privilege gating
        step("R5 sup only set", 0, 0, 0, 0, 0, 0, 0, 1, mk_ctrl(3, 0, 1, 1, 0, 1, 0));
        step("R5 prob blocked", 1, 1, 64'h1000, 8, 0);
        step("R5 sup hit", 1, 1, 64'h1000, 8, 1);
        step("R5 hyp blocked", 1, 1, 64'h1000, 8, 2);
        step("R5 code3 never", 1, 1, 64'h1000, 8, 3);
        step("R5 all off", 0, 0, 0, 0, 0, 0, 0, 1, mk_ctrl(3, 0, 1, 1, 0, 0, 0));
        step("R5 all off sup", 1, 1, 64'h1000, 8, 1);
        // R6: same-cycle write uses old value, next cycle uses new
        step("R6 enable all", 0, 0, 0, 0, 0, 0, 0, 1, mk_ctrl(0, 0, 1, 1, 1, 1, 1));
        step("R6 same cycle old", 1, 1, 64'h1000, 8, 0, 0, 0, 1, mk_ctrl(0, 0, 0, 0, 0, 0, 0));
        step("R6 next cycle new", 1, 1, 64'h1000, 8, 0);
        step("R6 base move same", 1, 1, 64'h1000, 8, 0, 1, 64'h2000, 1, mk_ctrl(0, 0, 1, 1, 1, 1, 1));
        step("R6 base move after", 1, 1, 64'h2000, 8, 0);
        // R8: cross-range flag has no matching effect
        step("R8 set flag", 0, 0, 0, 0, 0, 0, 0, 1, mk_ctrl(0, 1, 1, 1, 1, 1, 1));
        step("R8 hit unchanged", 1, 1, 64'h2004, 2, 2);
        step("R8 miss unchanged", 1, 1, 64'h2008, 8, 2);
        // R9: no wrap, valid and size gating
        step("R9 top base", 0, 0, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, mk_ctrl(1, 0, 1, 1, 1, 1, 1));
        step("R9 zero addr no wrap", 1, 1, 64'h0, 8, 0);
        step("R9 top hit", 1, 1, 64'hFFFF_FFFF_FFFF_FFFC, 8, 0);
        step("R9 size zero", 1, 1, 64'hFFFF_FFFF_FFFF_FFF8, 0, 0);
        step("R9 not valid", 0, 1, 64'hFFFF_FFFF_FFFF_FFF8, 8, 0);
        // Mixed traffic around a large window, compared every clock
        step("R3 wide window", 0, 0, 0, 0, 0, 1, 64'h8000, 1, mk_ctrl(63, 0, 1, 1, 1, 1, 1));
        for (int i = 0; i < 400; i++) begin
            logic [63:0] ea = 64'h7F00 + 64'($urandom_range(0, 1023));
            bit cw = ($urandom_range(0, 15) == 0);
            step("R3 R4 R5 mixed", 1, $urandom_range(0, 1), ea, $urandom_range(0, 15),
                 2'($urandom_range(0, 3)), 0, 0, cw,
                 mk_ctrl($urandom_range(0, 63), $urandom_range(0, 1), $urandom_range(0, 1),
                         $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                         $urandom_range(0, 1)));
        end
        // R7: reset clears after use
        rst = 1;
        @(negedge clk);
        rst = 0;
        m_base = '0; m_ctrl = '0;
        chk("R7 rereset base", base_rdata, 64'd0);
        chk("R7 rereset ctrl", ctrl_rdata, 64'd0);
        chk("R7 rereset hit", {63'b0, wp_hit}, 64'd0);
        finish_run();
    end
endmodule